// File: doc/BRIEF.md
# Multidrop Scan Bridge Address Selector

This block decides whether one scan bridge on a shared test backplane takes part in the next scan operations. It sits next to a standard 16-state TAP controller and runs on the backplane test clock. Each time the TAP controller passes through Update-IR, the selector classifies the captured instruction register value. That value is either an address or an instruction. An address can match the bridge's static slot identifier, or it can be one of the reserved shared addresses: broadcast, interrogation, or one of four multicast groups.

The registered `sel` output gates the bridge's data registers and local ports. Two further flags tell the surrounding logic how the selection was reached. Once a bridge is selected, it ignores further addresses until a go-to-wait instruction arrives. A bridge honours go-to-wait in every state, and the instruction returns every bridge that sees it to the unselected waiting state. Membership in each multicast group is a bit that can only be written while the bridge is selected.

Top module: `scan_addr_sel`

## Requirements
- R1: A synchronous active-high `rst` clears `sel`, `shared_sel`, `query_sel` and all multicast membership bits by the next clock edge.
- R2: With `ir[7]`=0, an address in the range 1..121 that equals `slot` selects an unselected bridge on `upd_ir`, with `shared_sel` and `query_sel` low. 121 is the top of the unique range.
- R3: Address value 0 never selects the bridge, whatever the value of `slot`.
- R4: An address that differs from `slot` leaves an unselected bridge unselected. A `slot` value of 0 or 122..127 can never be reached by an individual match.
- R5: Broadcast address 126 selects an unselected bridge and sets `shared_sel`.
- R6: Multicast address 122+g (g = 0..3) selects an unselected bridge and sets `shared_sel` only if membership bit g is set. On `upd_dr`, membership is loaded from `dr_data` (bit g for group g) only while `sel` is high; a write made while unselected has no effect.
- R7: Interrogation address 127 selects an unselected bridge and sets `query_sel`, not `shared_sel`.
- R8: The go-to-wait instruction (`ir` = 8'hFF) clears `sel`, `shared_sel` and `query_sel` from any state.
- R9: While selected, any `ir` value other than go-to-wait leaves the state unchanged. While unselected, instruction values (`ir[7]`=1) other than go-to-wait are ignored.
- R10: Outputs change only on the clock edge following an `upd_ir` pulse, or on reset. `ir` changes without `upd_ir` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane test clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_ir | input | 1 | TAP controller is in Update-IR this cycle |
| upd_dr | input | 1 | TAP controller is in Update-DR this cycle (membership write) |
| ir | input | 8 | Instruction register value; bit 7 set marks an instruction, clear marks an address in bits 6:0 |
| slot | input | 7 | Static slot identifier |
| dr_data | input | 4 | Membership bits offered on Update-DR, bit g for group g |
| sel | output | 1 | Bridge is selected |
| shared_sel | output | 1 | Selection came from a broadcast or multicast address |
| query_sel | output | 1 | Selection came from the interrogation address |

## Verification
The corner cases are the edges of the address space:
- A slot strapped to 0 with a zero address must not select; a design that compared raw equality would answer.
- A slot strapped to a multicast code must not be reachable as an individual address; a design that matched individually would bypass group membership.
- Address 121 must still select, so an off-by-one range check would lose the last slot.
- Membership writes made while unselected must be dropped; a design that accepted them would let every bridge on the backplane rewrite its groups.
- Addresses arriving while already selected must be ignored, or a second address would silently retarget the selection.
- Go-to-wait must clear selection from each of the unique, shared and interrogation states, including the flags.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_UNIQ  = 3'd1,
    K_GROUP = 3'd2,
    K_BCAST = 3'd3,
    K_QUERY = 3'd4,
    K_WAIT  = 3'd5
  } addr_kind_t;
endpackage

// File: rtl/addr_decode.sv
module addr_decode
  import sel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GROUPS = 4
) (
  input  logic [ADDR_W:0]   ir,
  input  logic [ADDR_W-1:0] slot,
  output addr_kind_t        kind,
  output logic [GROUPS-1:0] grp_oh
);
  localparam int AMAX   = (1 << ADDR_W) - 1;
  localparam int AQUERY = AMAX;
  localparam int ABCAST = AMAX - 1;
  localparam int AMC    = AMAX - 1 - GROUPS;
  localparam logic [ADDR_W-1:0] QA = ADDR_W'(AQUERY);
  localparam logic [ADDR_W-1:0] BA = ADDR_W'(ABCAST);

  logic [ADDR_W-1:0] a;
  logic              is_instr;
  assign a        = ir[ADDR_W-1:0];
  assign is_instr = ir[ADDR_W];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(AMC + g);
    assign grp_oh[g] = !is_instr && (a == GA);
  end

  always_comb begin
    kind = K_NONE;
    if (is_instr) begin
      if (&ir) kind = K_WAIT;
    end else if (a == '0) begin
      kind = K_NONE;
    end else if (a == QA) begin
      kind = K_QUERY;
    end else if (a == BA) begin
      kind = K_BCAST;
    end else if (|grp_oh) begin
      kind = K_GROUP;
    end else if (a == slot) begin
      kind = K_UNIQ;
    end
  end
endmodule

// File: rtl/grp_member.sv
module grp_member #(
  parameter int GROUPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [GROUPS-1:0] wdata,
  output logic [GROUPS-1:0] member
);
  always_ff @(posedge clk) begin
    if (rst)        member <= '0;
    else if (wr_en) member <= wdata;
  end
endmodule

// File: rtl/sel_state.sv
module sel_state
  import sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_ir,
  input  addr_kind_t kind,
  input  logic       grp_hit,
  output logic       sel,
  output logic       shared_sel,
  output logic       query_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= 1'b0;
      shared_sel <= 1'b0;
      query_sel  <= 1'b0;
    end else if (upd_ir) begin
      if (kind == K_WAIT) begin
        sel        <= 1'b0;
        shared_sel <= 1'b0;
        query_sel  <= 1'b0;
      end else if (!sel) begin
        case (kind)
          K_UNIQ:  sel <= 1'b1;
          K_BCAST: begin
            sel        <= 1'b1;
            shared_sel <= 1'b1;
          end
          K_GROUP: if (grp_hit) begin
            sel        <= 1'b1;
            shared_sel <= 1'b1;
          end
          K_QUERY: begin
            sel       <= 1'b1;
            query_sel <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scan_addr_sel.sv
module scan_addr_sel
  import sel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GROUPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_ir,
  input  logic              upd_dr,
  input  logic [ADDR_W:0]   ir,
  input  logic [ADDR_W-1:0] slot,
  input  logic [GROUPS-1:0] dr_data,
  output logic              sel,
  output logic              shared_sel,
  output logic              query_sel
);
  addr_kind_t        kind;
  logic [GROUPS-1:0] grp_oh;
  logic [GROUPS-1:0] member;
  logic              grp_hit;

  addr_decode #(.ADDR_W(ADDR_W), .GROUPS(GROUPS)) u_dec (
    .ir(ir), .slot(slot), .kind(kind), .grp_oh(grp_oh)
  );

  grp_member #(.GROUPS(GROUPS)) u_mem (
    .clk(clk), .rst(rst), .wr_en(upd_dr && sel),
    .wdata(dr_data), .member(member)
  );

  assign grp_hit = |(grp_oh & member);

  sel_state u_st (
    .clk(clk), .rst(rst), .upd_ir(upd_ir), .kind(kind),
    .grp_hit(grp_hit), .sel(sel), .shared_sel(shared_sel),
    .query_sel(query_sel)
  );
endmodule

// File: rtl/scan_addr_sel_chk.sv
module scan_addr_sel_chk #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            upd_ir,
  input logic [ADDR_W:0] ir,
  input logic            sel,
  input logic            shared_sel,
  input logic            query_sel
);
  localparam int AMAX = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W:0] IR_BCAST = (ADDR_W+1)'(AMAX - 1);
  localparam logic [ADDR_W:0] IR_QUERY = (ADDR_W+1)'(AMAX);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!sel && !shared_sel && !query_sel));

  p_zero_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_ir && ir == '0 && !sel) |=> !sel);

  p_bcast_shared_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_ir && ir == IR_BCAST && !sel) |=> (sel && shared_sel));

  p_shared_implies_sel_r6: assert property (@(posedge clk) disable iff (rst)
    shared_sel |-> sel);

  p_query_only_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_ir && ir == IR_QUERY && !sel) |=> (sel && query_sel && !shared_sel));

  p_wait_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_ir && (&ir)) |=> (!sel && !shared_sel && !query_sel));

  p_selected_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_ir && sel && !(&ir)) |=> ($stable(sel) && $stable(shared_sel) && $stable(query_sel)));

  p_hold_no_update_r10: assert property (@(posedge clk) disable iff (rst)
    !upd_ir |=> ($stable(sel) && $stable(shared_sel) && $stable(query_sel)));
endmodule

bind scan_addr_sel scan_addr_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .upd_ir(upd_ir), .ir(ir),
  .sel(sel), .shared_sel(shared_sel), .query_sel(query_sel)
);

// File: tb/sim_scan_addr_sel.sv
`timescale 1ns/1ps
module sim_scan_addr_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_ir = 1'b0;
  logic       upd_dr = 1'b0;
  logic [7:0] ir = 8'h00;
  logic [6:0] slot = 7'd0;
  logic [3:0] dr_data = 4'h0;
  logic       sel, shared_sel, query_sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic       m_sel, m_sh, m_q;
  logic [3:0] m_mem;

  always #4 clk = ~clk;

  scan_addr_sel u0 (
    .clk(clk), .rst(rst), .upd_ir(upd_ir), .upd_dr(upd_dr), .ir(ir),
    .slot(slot), .dr_data(dr_data), .sel(sel), .shared_sel(shared_sel),
    .query_sel(query_sel)
  );

  function automatic string tag_of(input logic [7:0] v, input logic s);
    if (v == 8'hFF) return "R8";
    if (s) return "R9";
    if (v[7]) return "R9";
    if (v == 8'd0) return "R3";
    if (v == 8'd127) return "R7";
    if (v == 8'd126) return "R5";
    if (v >= 8'd122) return "R6";
    if (v[6:0] == slot) return "R2";
    return "R4";
  endfunction

  task automatic model_ir(input logic [7:0] v);
    if (v == 8'hFF) begin
      m_sel = 0; m_sh = 0; m_q = 0;
    end else if (!m_sel && !v[7]) begin
      if (v == 8'd127) begin m_sel = 1; m_q = 1; end
      else if (v == 8'd126) begin m_sel = 1; m_sh = 1; end
      else if (v >= 8'd122) begin
        if (m_mem[v - 8'd122]) begin m_sel = 1; m_sh = 1; end
      end else if (v != 8'd0 && v[6:0] == slot) m_sel = 1;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if ({sel, shared_sel, query_sel} !== {m_sel, m_sh, m_q}) begin
      errors++;
      $display("FAIL %s: sel/shared/query got %b%b%b expected %b%b%b",
               tag, sel, shared_sel, query_sel, m_sel, m_sh, m_q);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_sel = 0; m_sh = 0; m_q = 0; m_mem = 4'h0;
  endtask

  task automatic do_ir(input logic [7:0] v, input string tag);
    string t;
    t = (tag == "") ? tag_of(v, m_sel) : tag;
    @(negedge clk); ir = v; upd_ir = 1'b1;
    @(negedge clk); upd_ir = 1'b0;
    model_ir(v);
    check(t);
  endtask

  task automatic do_dr(input logic [3:0] d);
    @(negedge clk); dr_data = d; upd_dr = 1'b1;
    @(negedge clk); upd_dr = 1'b0;
    if (m_sel) m_mem = d;
    check("R6");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    m_sel = 0; m_sh = 0; m_q = 0; m_mem = 4'h0;
    do_reset();
    check("R1");

    slot = 7'd5;
    do_ir(8'h05, "R2");
    do_ir(8'h09, "R9");
    do_ir(8'h85, "R9");
    do_ir(8'hFF, "R8");
    slot = 7'd0;
    do_ir(8'h00, "R3");
    slot = 7'd5;
    do_ir(8'h06, "R4");
    slot = 7'd123;
    do_ir(8'd123, "R4");
    do_dr(4'hF);
    do_ir(8'd122, "R6");
    do_ir(8'd126, "R5");
    do_dr(4'b0010);
    do_ir(8'hFF, "R8");
    do_ir(8'd123, "R6");
    do_ir(8'hFF, "R8");
    do_ir(8'd122, "R6");
    do_ir(8'd127, "R7");
    do_ir(8'hFF, "R8");
    do_ir(8'h80, "R9");
    slot = 7'd121;
    do_ir(8'd121, "R2");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ir = 8'hFF;
      check("R10");
    end
    do_reset();
    check("R1");
    do_ir(8'd123, "R1");

    for (int i = 0; i < 500; i++) begin
      int c;
      c = $urandom_range(0, 9);
      if (c == 0) slot = 7'($urandom_range(0, 127));
      if (c == 1) do_dr(4'($urandom_range(0, 15)));
      else if (c == 2) do_ir(8'hFF, "");
      else if (c == 3) do_ir({1'b0, slot}, "");
      else if (c == 4) begin
        @(negedge clk); ir = 8'($urandom); check("R10");
      end else begin
        v = (c < 7) ? 8'($urandom_range(120, 127)) : 8'($urandom);
        do_ir(v, "");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule